// File: doc/BRIEF.md
# Carry Select Adder with Selectable Approximate Low-Order Cells

This block adds two 16-bit operands and a carry-in and returns a 16-bit sum with a carry-out. The operands are cut into four 4-bit slices. The lowest slice is a simple ripple chain that the external carry-in drives. Each of the three upper slices computes its result twice, once with an assumed carry-in of 0 and once with an assumed carry-in of 1. The real carry arriving from the slice below then picks one of the two results. This keeps the long ripple path out of the upper slices.

A static two-bit mode input sets the kind of full-adder cell used in the eight low-order bit positions. Three kinds are available: an exact cell and two approximate cells. Each approximate cell has a fixed, known wrong truth table and uses less logic than the exact cell. The eight upper positions always use exact cells, so the error stays in the low byte and in the carry it passes up. The result is captured in an optional output register, which is present by default. With that register there is one cycle of latency, and reset clears the outputs.

The adder takes a new operand set on every clock and has no stall condition. For that reason it carries no valid/ready handshake: a result is due a fixed number of cycles after its inputs, and the consumer samples it at that time.

Top module: `csa_approx_adder`

## Requirements
- R1: With mode 2'b00 (exact), {cout, sum} equals a + b + cin as a 17-bit unsigned value, for every input.
- R2: With mode 2'b01, each of bit positions 0..7 acts as a cell with s = x ^ (y | c) and carry = x | (y & c), where x and y are the operand bits at that position and c is the carry into it. For example, 0 + 0 with cin = 1 gives sum 16'h0001.
- R3: With mode 2'b10, each of bit positions 0..7 acts as a cell with s = (x ^ y) & ~c and carry = c. For example, 0 + 0 with cin = 1 gives sum 16'h0100 with cout 0.
- R4: In every mode, bit positions 8..15 and cout are the exact sum of a[15:8], b[15:8] and the carry that leaves bit position 7.
- R5: Mode 2'b11 behaves exactly like mode 2'b00.
- R6: In each upper 4-bit slice, the output equals what a plain ripple of the same cells would give when driven by the true carry from the slice below. This holds for carries that run through all slices, such as 16'hFFFF + 0 with cin = 1, which gives sum 0 and cout 1.
- R7: With the output register present (the default), sum and cout show the result for the inputs sampled at the previous rising clock edge. While rst_n is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| mode | input | 2 | Cell kind for the low byte: 00 exact, 01 approximate cell 1, 10 approximate cell 2, 11 exact |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |

## Verification
Every result is due exactly one clock after its operands and mode are presented. The bench drives a new input set on a falling edge. It then compares sum and cout at the next falling edge, which comes after the single rising edge that loads the output register. Each comparison is against a behavioural bit-serial model of the selected cell kind. The model is not true addition, except in the exact modes. The in-design properties use $past over one cycle to relate the registered outputs to the operands that produced them.

// File: rtl/csa_approx_pkg.sv
package csa_approx_pkg;

  typedef enum logic [1:0] {
    CELL_EXACT = 2'b00,
    CELL_APX1  = 2'b01,
    CELL_APX2  = 2'b10,
    CELL_SPARE = 2'b11
  } cell_mode_e;

  // Returns {carry, sum} for one bit position using the selected cell kind.
  function automatic logic [1:0] cell_eval(cell_mode_e m, logic x, logic y, logic ci);
    logic s, co;
    case (m)
      CELL_APX1: begin
        s  = x ^ (y | ci);
        co = x | (y & ci);
      end
      CELL_APX2: begin
        s  = (x ^ y) & ~ci;
        co = ci;
      end
      default: begin
        s  = x ^ y ^ ci;
        co = (x & y) | (y & ci) | (x & ci);
      end
    endcase
    return {co, s};
  endfunction

endpackage

// File: rtl/csa_fa_cell.sv
module csa_fa_cell
  import csa_approx_pkg::*;
#(
  parameter bit APPROX_OK = 1'b0
) (
  input  cell_mode_e mode,
  input  logic       x,
  input  logic       y,
  input  logic       ci,
  output logic       s,
  output logic       co
);
  cell_mode_e eff_mode;
  logic [1:0] res;

  assign eff_mode = APPROX_OK ? mode : CELL_EXACT;
  assign res      = cell_eval(eff_mode, x, y, ci);
  assign s        = res[0];
  assign co       = res[1];
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple
  import csa_approx_pkg::*;
#(
  parameter int W           = 4,
  parameter int APPROX_BITS = 0
) (
  input  cell_mode_e     mode,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  input  logic           ci,
  output logic [W-1:0]   s,
  output logic           co
);
  logic [W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csa_fa_cell #(.APPROX_OK(i < APPROX_BITS)) u_cell (
      .mode(mode), .x(x[i]), .y(y[i]), .ci(c[i]), .s(s[i]), .co(c[i+1])
    );
  end

  assign co = c[W];
endmodule

// File: rtl/csa_select_block.sv
module csa_select_block
  import csa_approx_pkg::*;
#(
  parameter int W           = 4,
  parameter int APPROX_BITS = 0
) (
  input  cell_mode_e   mode,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] s_c0, s_c1;
  logic         co_c0, co_c1;

  csa_ripple #(.W(W), .APPROX_BITS(APPROX_BITS)) u_zero (
    .mode(mode), .x(x), .y(y), .ci(1'b0), .s(s_c0), .co(co_c0)
  );
  csa_ripple #(.W(W), .APPROX_BITS(APPROX_BITS)) u_one (
    .mode(mode), .x(x), .y(y), .ci(1'b1), .s(s_c1), .co(co_c1)
  );

  assign s  = ci ? s_c1  : s_c0;
  assign co = ci ? co_c1 : co_c0;
endmodule

// File: rtl/csa_approx_adder.sv
module csa_approx_adder
  import csa_approx_pkg::*;
#(
  parameter int WIDTH        = 16,
  parameter int SLICE        = 4,
  parameter int APPROX_WIDTH = 8,
  parameter bit REG_OUT      = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSLICE = WIDTH / SLICE;
  localparam int HI_W   = WIDTH - APPROX_WIDTH;
  localparam int MID    = APPROX_WIDTH / SLICE;

  cell_mode_e       cmode;
  logic [NSLICE:0]  carry;
  logic [WIDTH-1:0] sum_c;

  assign cmode    = cell_mode_e'(mode);
  assign carry[0] = cin;

  csa_ripple #(
    .W(SLICE),
    .APPROX_BITS((APPROX_WIDTH > SLICE) ? SLICE : APPROX_WIDTH)
  ) u_slice0 (
    .mode(cmode), .x(a[SLICE-1:0]), .y(b[SLICE-1:0]), .ci(carry[0]),
    .s(sum_c[SLICE-1:0]), .co(carry[1])
  );

  for (genvar k = 1; k < NSLICE; k++) begin : g_slice
    localparam int REM = APPROX_WIDTH - k * SLICE;
    localparam int NAP = (REM <= 0) ? 0 : ((REM > SLICE) ? SLICE : REM);
    csa_select_block #(.W(SLICE), .APPROX_BITS(NAP)) u_sel (
      .mode(cmode),
      .x(a[k*SLICE +: SLICE]), .y(b[k*SLICE +: SLICE]),
      .ci(carry[k]),
      .s(sum_c[k*SLICE +: SLICE]), .co(carry[k+1])
    );
  end

  if (REG_OUT) begin : g_reg
    logic [WIDTH-1:0] sum_q;
    logic             cout_q;
    logic             primed;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
        primed <= 1'b0;
      end else begin
        sum_q  <= sum_c;
        cout_q <= carry[NSLICE];
        primed <= 1'b1;
      end
    end

    assign sum  = sum_q;
    assign cout = cout_q;

    // R1: exact mode gives true addition one cycle later
    a_r1_exact_add: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(mode) == 2'b00) |->
        {cout, sum} == (WIDTH+1)'($past(a)) + (WIDTH+1)'($past(b)) + (WIDTH+1)'($past(cin)));

    // R5: spare code behaves as exact
    a_r5_spare_exact: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(mode) == 2'b11) |->
        {cout, sum} == (WIDTH+1)'($past(a)) + (WIDTH+1)'($past(b)) + (WIDTH+1)'($past(cin)));

    // R2: bit 0 follows approximate cell 1
    a_r2_cell1_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(mode) == 2'b01) |->
        sum[0] == ($past(a[0]) ^ ($past(b[0]) | $past(cin))));

    // R3: bit 0 follows approximate cell 2
    a_r3_cell2_bit0: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && $past(mode) == 2'b10) |->
        sum[0] == (($past(a[0]) ^ $past(b[0])) & ~$past(cin)));

    // R4: the upper part is exact given the carry leaving the low part
    a_r4_upper_exact: assert property (@(posedge clk) disable iff (!rst_n)
      primed |->
        {cout, sum[WIDTH-1:APPROX_WIDTH]} ==
          (HI_W+1)'($past(a[WIDTH-1:APPROX_WIDTH])) +
          (HI_W+1)'($past(b[WIDTH-1:APPROX_WIDTH])) +
          (HI_W+1)'($past(carry[MID])));
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = carry[NSLICE];
  end
endmodule

// File: tb/csa_approx_adder_test.sv
module csa_approx_adder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] sum;
  logic        cout;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  csa_approx_adder uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .mode(mode),
    .sum(sum), .cout(cout)
  );

  // Bit-serial model of the selected cell kind (low byte), exact above.
  function automatic logic [16:0] model(logic [15:0] x, logic [15:0] y, logic c, logic [1:0] m);
    logic [15:0] s;
    logic        cy;
    cy = c;
    for (int i = 0; i < 16; i++) begin
      logic xi, yi;
      xi = x[i];
      yi = y[i];
      if (i < 8 && m == 2'b01) begin
        s[i] = xi ^ (yi | cy);
        cy   = xi | (yi & cy);
      end else if (i < 8 && m == 2'b10) begin
        s[i] = (xi ^ yi) & ~cy;
      end else begin
        s[i] = xi ^ yi ^ cy;
        cy   = (xi & yi) | (yi & cy) | (xi & cy);
      end
    end
    return {cy, s};
  endfunction

  task automatic check(string req, logic [16:0] got, logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(string req, logic [15:0] x, logic [15:0] y, logic c, logic [1:0] m);
    @(negedge clk);
    a = x; b = y; cin = c; mode = m;
    @(negedge clk);
    check(req, {cout, sum}, model(x, y, c, m));
  endtask

  task automatic expect_val(string req, logic [15:0] x, logic [15:0] y, logic c,
                            logic [1:0] m, logic [16:0] exp);
    @(negedge clk);
    a = x; b = y; cin = c; mode = m;
    @(negedge clk);
    check(req, {cout, sum}, exp);
  endtask

  initial begin
    #(10 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    a = 16'hFFFF; b = 16'hFFFF; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R7 reset", {cout, sum}, 17'h0);
    rst_n = 1'b1;

    // R1 exact corners
    expect_val("R1 zero", 16'h0000, 16'h0000, 1'b0, 2'b00, 17'h00000);
    expect_val("R1 max", 16'hFFFF, 16'hFFFF, 1'b1, 2'b00, 17'h1FFFF);
    expect_val("R1 mid", 16'h1234, 16'h4321, 1'b0, 2'b00, 17'h05555);
    // R6 carry through every slice
    expect_val("R6 full carry", 16'hFFFF, 16'h0000, 1'b1, 2'b00, 17'h10000);
    expect_val("R6 slice edge", 16'h00FF, 16'h0001, 1'b0, 2'b00, 17'h00100);
    // R2 / R3 directed corner 0 + 0 + 1
    expect_val("R2 cell1 001", 16'h0000, 16'h0000, 1'b1, 2'b01, 17'h00001);
    expect_val("R3 cell2 001", 16'h0000, 16'h0000, 1'b1, 2'b10, 17'h00100);
    // R3: cell2 drops sum where carry in, carries up unchanged
    expect_val("R3 cell2 ones", 16'h00FF, 16'h0000, 1'b1, 2'b10, 17'h00100);
    // R2: cell1 with a=1 forces carry
    expect_val("R2 cell1 a", 16'h0001, 16'h0000, 1'b0, 2'b01, 17'h00003);
    // R4 upper exact with carry from approximate low byte
    expect_val("R4 upper", 16'hFF00, 16'h0000, 1'b1, 2'b10, 17'h10000);
    // R5 spare code is exact
    expect_val("R5 spare", 16'h00FF, 16'h0001, 1'b1, 2'b11, 17'h00101);

    // R7 latency: output holds previous value until the edge
    @(negedge clk);
    a = 16'h0010; b = 16'h0020; cin = 1'b0; mode = 2'b00;
    #1;
    check("R7 hold", {cout, sum}, 17'h00101);
    @(negedge clk);
    check("R7 latency", {cout, sum}, 17'h00030);

    // Random sweep of every mode
    for (int m = 0; m < 4; m++) begin
      for (int n = 0; n < 600; n++) begin
        logic [15:0] x, y;
        x = 16'($urandom);
        y = 16'($urandom);
        case (m)
          0: apply("R1 random", x, y, 1'($urandom), 2'b00);
          1: apply("R2 random", x, y, 1'($urandom), 2'b01);
          2: apply("R3 random", x, y, 1'($urandom), 2'b10);
          default: apply("R5 random", x, y, 1'($urandom), 2'b11);
        endcase
      end
    end

    // R4 / R6: upper result against true addition of upper bytes and low carry
    for (int n = 0; n < 300; n++) begin
      logic [15:0] x, y;
      logic [16:0] r;
      logic [1:0]  m;
      x = 16'($urandom);
      y = 16'($urandom);
      m = 2'($urandom % 3);
      r = model(x, y, 1'b0, m);
      apply("R6 random", x, y, 1'b0, m);
      checks++;
      if (r[16:8] !== ({1'b0, x[15:8]} + {1'b0, y[15:8]} + 9'(model(x & 16'h00FF, y & 16'h00FF, 1'b0, m) >> 8))) begin
        errors++;
        $display("FAIL R4 model: got %h expected upper exact", r);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule